// File: doc/BRIEF.md
# Routed GPIO Trigger and Interrupt Steering Unit

This unit watches every input pin of a group of GPIO ports and turns pin activity into interrupts. Each pin carries its own trigger code (rising edge, falling edge, both edges, high level or low level), an inversion bit, an enable bit and a route field. The route field picks which of several interrupt outputs the pin reports to, so each output can be wired to a different processor. The unit then splits the interrupt work for one port group among those processors.

Software sets up each pin through a small word-wide register interface. It reads one status word per output, where each bit shows a pin that is pending on that output. It acknowledges edge events by writing ones to that same status word. Every output is an active-high level line. The line is high while any pin routed to that output is pending.

Top module: `gpirq_ctrl`

## Requirements
- R1: After reset every configuration word reads 0. That means trigger code 0, not inverted, disabled, and routed to output 0. Every status word reads 0 and every interrupt output is low.
- R2: Trigger code 1 (bits [3:0] of a pin's configuration word) sets the pin's pending bit on a low-to-high change of the pin. The bit is visible in status and on the interrupt output at the third rising clock edge after the pin changes. A high-to-low change does not set it.
- R3: Trigger code 2 sets the pending bit on a high-to-low change. Code 3 sets it on either change. Both have the same three-edge latency.
- R4: Trigger code 4 makes the pending bit follow the synchronized pin while it is high. Code 8 makes it follow while the pin is low. Writing a one to acknowledge a level-triggered pin has no effect.
- R5: Configuration bit 4 inverts the pin before trigger detection. With it set, code 1 fires on a falling pin, code 4 is active while the pin is low, and so on.
- R6: A pin whose enable bit (bit 5) is 0, or whose trigger code is not one of 1, 2, 3, 4 or 8, never reports pending. Clearing the enable bit drops any pending state on the next clock edge.
- R7: An edge-triggered pending bit stays set until software writes a 1 to its bit in the status word of the output it is routed to. Writing 0 to that bit leaves it set.
- R8: Bit i of the status word of output k is the pending state of pin i when the pin's route field (bits starting at 6) equals k. Interrupt output k is high exactly when that status word is non-zero.
- R9: Changing a pin's route field moves its pending state to the new output at once. A pin is never reported on two outputs. An acknowledge written to the old output does not clear it.
- R10: Addresses 0 to NPIN-1 hold the pin configuration words, which read back as written. Address NPIN+k is the status word of output k. Reads are combinational on the address. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPIN | Raw GPIO pin levels, asynchronous to clk_i |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address for both read and write |
| reg_wdata_i | input | DW | Write data: a configuration word, or an acknowledge mask |
| reg_rdata_o | output | DW | Read data for reg_addr_i |
| irq_o | output | OUTS | Active-high interrupt line per output |

## Verification
Each of the sixteen trigger codes is tried in both polarities. For each one the pin is held low, pulsed high, returned low, acknowledged and disabled. This separates the edge codes from the level codes, rising from falling detection, and the legal codes from the illegal ones. Every step reads all status words and all interrupt lines. A pin that shows up on the wrong output, or on two outputs, is caught at each step. Directed sequences then move a pending pin between outputs and acknowledge on the old output and then the new one. Two pins pending on one output are acknowledged one at a time, so the line must stay high until the last one is cleared.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

   localparam int TRIG_W        = 4;
   localparam int CFG_POL_BIT   = 4;
   localparam int CFG_EN_BIT    = 5;
   localparam int CFG_ROUTE_LSB = 6;

   localparam logic [TRIG_W-1:0] TRIG_RISE = 4'd1;
   localparam logic [TRIG_W-1:0] TRIG_FALL = 4'd2;
   localparam logic [TRIG_W-1:0] TRIG_BOTH = 4'd3;
   localparam logic [TRIG_W-1:0] TRIG_HIGH = 4'd4;
   localparam logic [TRIG_W-1:0] TRIG_LOW  = 4'd8;

   function automatic logic trig_is_edge(input logic [TRIG_W-1:0] c);
      return (c == TRIG_RISE) || (c == TRIG_FALL) || (c == TRIG_BOTH);
   endfunction

   function automatic logic trig_is_level(input logic [TRIG_W-1:0] c);
      return (c == TRIG_HIGH) || (c == TRIG_LOW);
   endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
)(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpirq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpirq_sync: W must be at least 1");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpirq_pin_cell.sv
module gpirq_pin_cell
   import gpirq_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sync_i,
   input  logic [TRIG_W-1:0] trig_i,
   input  logic              pol_i,
   input  logic              en_i,
   input  logic              clr_i,
   output logic              pend_o
);

   logic prev_q, pend_q, pend_d;
   logic now_v, old_v, edge_hit, lvl_hit, legal;

   assign now_v = sync_i ^ pol_i;
   assign old_v = prev_q ^ pol_i;
   assign legal = trig_is_edge(trig_i) | trig_is_level(trig_i);

   assign edge_hit = trig_is_edge(trig_i) &
                     ((trig_i[0] & now_v & ~old_v) | (trig_i[1] & ~now_v & old_v));
   assign lvl_hit  = ((trig_i == TRIG_HIGH) & now_v) | ((trig_i == TRIG_LOW) & ~now_v);

   always_comb begin
      if (!en_i || !legal)             pend_d = 1'b0;
      else if (trig_is_level(trig_i))  pend_d = lvl_hit;
      else                             pend_d = (pend_q & ~clr_i) | edge_hit;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= sync_i;
         pend_q <= pend_d;
      end
   end

   assign pend_o = pend_q;

   // R6: disabled or illegal code leaves nothing pending
   a_r6_off_stays_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i || !legal) |=> !pend_q);

   // R2: a true rising pin in rising mode raises pending
   a_r2_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && trig_i == TRIG_RISE && !pol_i && $rose(sync_i)) |=> pend_q);

   // R7: edge pending is sticky without an acknowledge
   a_r7_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && trig_is_edge(trig_i) && pend_q && !clr_i) |=> pend_q);

   // R4: high-level mode tracks the synchronized pin
   a_r4_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && trig_i == TRIG_HIGH && !pol_i) |=> (pend_q == $past(sync_i)));

endmodule

// File: rtl/gpirq_route.sv
module gpirq_route #(
   parameter int NPIN = 32,
   parameter int NOUT = 4,
   parameter int RW   = 2
)(
   input  logic [NPIN-1:0]      pend_i,
   input  logic [NPIN*RW-1:0]   route_i,
   output logic [NOUT*NPIN-1:0] status_o,
   output logic [NOUT-1:0]      irq_o
);

   for (genvar k = 0; k < NOUT; k++) begin : g_out
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         if (NOUT == 1) begin : g_single
            assign status_o[k*NPIN+i] = pend_i[i];
         end else begin : g_multi
            assign status_o[k*NPIN+i] = pend_i[i] & (route_i[i*RW +: RW] == RW'(k));
         end
      end
      assign irq_o[k] = |status_o[k*NPIN +: NPIN];
   end

endmodule

// File: rtl/gpirq_ctrl.sv
module gpirq_ctrl
   import gpirq_pkg::*;
#(
   parameter  int PINS_PER_PORT = 8,
   parameter  int PORTS         = 4,
   parameter  int OUTS          = 4,
   parameter  int SYNC_STAGES   = 2,
   localparam int NPIN          = PINS_PER_PORT * PORTS,
   localparam int RW            = (OUTS > 1) ? $clog2(OUTS) : 1,
   localparam int CFG_W         = CFG_ROUTE_LSB + RW,
   localparam int DW            = (NPIN > CFG_W) ? NPIN : CFG_W,
   localparam int AW            = $clog2(NPIN + OUTS)
)(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NPIN-1:0] pins_i,
   input  logic            reg_we_i,
   input  logic [AW-1:0]   reg_addr_i,
   input  logic [DW-1:0]   reg_wdata_i,
   output logic [DW-1:0]   reg_rdata_o,
   output logic [OUTS-1:0] irq_o
);

   if (PINS_PER_PORT < 1 || PORTS < 1 || OUTS < 1) begin : g_bad_dims
      $error("gpirq_ctrl: pin, port and output counts must be at least 1");
   end

   logic [CFG_W-1:0]     cfg_q [NPIN];
   logic [NPIN-1:0]      sync_w, pend_w, clr_w;
   logic [RW-1:0]        rsel_w [NPIN];
   logic [NPIN*RW-1:0]   route_flat;
   logic [OUTS*NPIN-1:0] status_w;

   // configuration storage
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < NPIN; i++) cfg_q[i] <= '0;
      end else if (reg_we_i) begin
         for (int i = 0; i < NPIN; i++)
            if (reg_addr_i == AW'(i)) cfg_q[i] <= reg_wdata_i[CFG_W-1:0];
      end
   end

   gpirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pins_i),
      .q_o   (sync_w)
   );

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      if (OUTS == 1) begin : g_one_route
         assign rsel_w[i] = '0;
      end else begin : g_route
         assign rsel_w[i] = cfg_q[i][CFG_ROUTE_LSB +: RW];
      end
      assign route_flat[i*RW +: RW] = rsel_w[i];
      assign clr_w[i] = reg_we_i & reg_wdata_i[i] &
                        (reg_addr_i == (AW'(NPIN) + AW'(rsel_w[i])));

      gpirq_pin_cell u_cell (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .sync_i(sync_w[i]),
         .trig_i(cfg_q[i][TRIG_W-1:0]),
         .pol_i (cfg_q[i][CFG_POL_BIT]),
         .en_i  (cfg_q[i][CFG_EN_BIT]),
         .clr_i (clr_w[i]),
         .pend_o(pend_w[i])
      );
   end

   gpirq_route #(.NPIN(NPIN), .NOUT(OUTS), .RW(RW)) u_route (
      .pend_i  (pend_w),
      .route_i (route_flat),
      .status_o(status_w),
      .irq_o   (irq_o)
   );

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      for (int i = 0; i < NPIN; i++)
         if (reg_addr_i == AW'(i)) reg_rdata_o = DW'(cfg_q[i]);
      for (int k = 0; k < OUTS; k++)
         if (reg_addr_i == AW'(NPIN + k)) reg_rdata_o = DW'(status_w[k*NPIN +: NPIN]);
   end

   // R9: a pending pin appears on at most one output
   for (genvar i = 0; i < NPIN; i++) begin : g_chk
      logic [OUTS-1:0] col;
      for (genvar k = 0; k < OUTS; k++) begin : g_col
         assign col[k] = status_w[k*NPIN+i];
      end
      a_r9_single_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $onehot0(col) && (pend_w[i] == (|col)));
   end

endmodule

// File: tb/test_gpirq_ctrl.sv
`timescale 1ns/1ps
module test_gpirq_ctrl;

   localparam int PPP = 4, NPORT = 2, NOUT = 4;
   localparam int N = PPP * NPORT;   // 8 pins
   localparam int AW = 4, DW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    pins = '0;
   logic            we = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [DW-1:0]   wdata = '0;
   logic [DW-1:0]   rdata;
   logic [NOUT-1:0] irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   gpirq_ctrl #(.PINS_PER_PORT(PPP), .PORTS(NPORT), .OUTS(NOUT)) i_gpirq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   always #2 clk = ~clk;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      we = 1'b1; addr = AW'(a); wdata = d;
      @(posedge clk); @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      addr = AW'(a);
      #1 d = rdata;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] cfg(input int c, input int p, input int en, input int r);
      return DW'((r << 6) | (en << 5) | (p << 4) | c);
   endfunction

   function automatic bit lvl_of(input int c, input int p, input int raw);
      bit v = bit'(raw ^ p);
      if (c == 4) return v;
      if (c == 8) return !v;
      return 1'b0;
   endfunction

   function automatic string tag_of(input int c, input int p);
      if (!(c == 1 || c == 2 || c == 3 || c == 4 || c == 8)) return "R6";
      if (p != 0) return "R5";
      if (c == 1) return "R2";
      if (c == 2 || c == 3) return "R3";
      return "R4";
   endfunction

   // R8: status word and irq line of every output against one pin's expected state
   task automatic check_outs(input int idx, input int r, input bit e, input string req);
      logic [DW-1:0] d;
      for (int k = 0; k < NOUT; k++) begin
         rd(N + k, d);
         chk(req, $sformatf("R8 status of out %0d", k), int'(d),
             (k == r && e) ? (1 << idx) : 0);
      end
      chk(req, "R8 irq lines", int'(irq), e ? (1 << r) : 0);
   endtask

   initial begin
      logic [DW-1:0] d;
      tick(5);
      rst_n = 1'b1;
      tick(2);

      // R1: reset state
      for (int a = 0; a < N + NOUT; a++) begin
         rd(a, d);
         chk("R1", $sformatf("reset read addr %0d", a), int'(d), 0);
      end
      chk("R1", "reset irq", int'(irq), 0);

      // sweep of all trigger codes and both polarities
      for (int c = 0; c < 16; c++) begin
         for (int p = 0; p < 2; p++) begin
            int idx, r;
            bit lvl, edg, rise_v, epend, e;
            string t;
            idx = c % N;
            r = (c + p) % NOUT;
            lvl = (c == 4 || c == 8);
            edg = (c >= 1 && c <= 3);
            rise_v = (p == 0);
            t = tag_of(c, p);

            wr(idx, cfg(c, p, 1, r));
            tick(4);
            check_outs(idx, r, lvl_of(c, p, 0), t);

            pins[idx] = 1'b1;
            tick(3);
            epend = edg && ((rise_v && (c & 1) != 0) || (!rise_v && (c & 2) != 0));
            e = lvl ? lvl_of(c, p, 1) : epend;
            check_outs(idx, r, e, t);

            pins[idx] = 1'b0;
            tick(3);
            epend = epend | (edg && ((!rise_v && (c & 1) != 0) || (rise_v && (c & 2) != 0)));
            e = lvl ? lvl_of(c, p, 0) : epend;
            check_outs(idx, r, e, t);

            // R7 / R4: acknowledge all bits of the routed output
            wr(N + r, '1);
            check_outs(idx, r, lvl ? lvl_of(c, p, 0) : 1'b0, lvl ? "R4" : "R7");

            // R6: disable clears
            wr(idx, '0);
            tick(1);
            check_outs(idx, r, 1'b0, "R6");
         end
      end

      // R9: rerouting a pending pin
      wr(3, cfg(1, 0, 1, 1));
      tick(2);
      pins[3] = 1'b1;
      tick(3);
      check_outs(3, 1, 1'b1, "R9");
      wr(3, cfg(1, 0, 1, 2));
      check_outs(3, 2, 1'b1, "R9");
      wr(N + 1, '1);
      check_outs(3, 2, 1'b1, "R9");
      wr(N + 2, DW'(1 << 3));
      check_outs(3, 2, 1'b0, "R9");
      pins[3] = 1'b0;
      tick(3);
      check_outs(3, 2, 1'b0, "R2");
      wr(3, '0);

      // R8 / R7: two pins on one output, acknowledged one at a time
      wr(4, cfg(3, 0, 1, 3));
      wr(5, cfg(3, 0, 1, 3));
      tick(2);
      pins[4] = 1'b1; pins[5] = 1'b1;
      tick(3);
      rd(N + 3, d);
      chk("R8", "two pins pending", int'(d), 'h30);
      chk("R8", "irq with two pins", int'(irq), 'b1000);
      wr(N + 3, DW'('h10));
      rd(N + 3, d);
      chk("R7", "zero bit in ack keeps pin 5", int'(d), 'h20);
      chk("R8", "irq held by remaining pin", int'(irq), 'b1000);
      wr(N + 3, DW'('h20));
      rd(N + 3, d);
      chk("R7", "second ack", int'(d), 0);
      chk("R8", "irq after last ack", int'(irq), 0);
      wr(4, '0); wr(5, '0);
      pins = '0;
      tick(3);

      // R10: configuration readback
      wr(6, DW'('hAB));
      rd(6, d);
      chk("R10", "config readback", int'(d), 'hAB);
      rd(7, d);
      chk("R10", "neighbour config untouched", int'(d), 0);
      wr(6, '0);
      tick(3);
      chk("R10", "irq after readback test", int'(irq), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule